// File: doc/BRIEF.md
# Byte-Readable Sixteen-Bit Timer Counter

This block is a free-running 16-bit up-counter that an 8-bit processor bus reads and writes one byte at a time. Each access targets either the upper or the lower byte. Reading the upper byte takes a snapshot of the lower byte in a one-byte holding register. A lower-byte read in the very next bus cycle returns that snapshot, so a back-to-back two-byte read returns one consistent 16-bit value even while the counter is advancing. A lower-byte read at any other time shows the live count. The holding register has no reset.

One parameter selects between two builds. The fixed build always counts the internal tick, because other timing functions on the chip use the same count. The flexible build can instead count rising edges of an external clock pin, which are first synchronised to the system clock. A write to the flexible build clears the count. Both builds take a special-mode input. When it is high, a write to the upper byte presets the count to 0xFFF8. This lets a test place the counter just below its wrap point.

Top module: `tmr_count16`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the count is 0x0000, so both bytes read as 0x00.
- R2: Each cycle with an active tick and no counter write adds one to the count. The count wraps from 0xFFFF to 0x0000.
- R3: A read of the upper byte (addr_i = 0) captures the lower byte of the count as it is in that cycle. A lower-byte read (addr_i = 1) in the next clock cycle returns the captured byte, even if the count has since advanced.
- R4: A lower-byte read that does not directly follow an upper-byte read returns the current lower byte of the count.
- R5: Reads never change the count. An upper-byte read returns the count's bits 15:8, and the count advances only on ticks.
- R6: In the fixed build (EXT_CAPABLE = 0) with special_i = 0, a write to either byte has no effect on the count.
- R7: In the flexible build (EXT_CAPABLE = 1) with special_i = 0, a write to either byte clears the count to 0x0000.
- R8: With special_i = 1, a write to the upper byte presets the count to 0xFFF8 in both builds. A lower-byte write has no effect on the count.
- R9: When a clear or preset write and an active tick fall in the same cycle, the write's value is loaded and the tick is lost.
- R10: In the flexible build with ext_sel_i = 1, the count advances once per rising edge of ext_clk_i, after synchronisation, and ignores tick_i. The fixed build always counts tick_i and ignores both ext_sel_i and ext_clk_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Internal count enable, one pulse per count step |
| ext_clk_i | input | 1 | Asynchronous external count clock (flexible build only) |
| ext_sel_i | input | 1 | Selects the external clock as the count source (flexible build only) |
| special_i | input | 1 | Special-mode bit: changes the effect of a write |
| sel_i | input | 1 | Bus access in this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | Byte select: 0 = upper byte, 1 = lower byte |
| wdata_i | input | BYTE_W | Write data; the value is not used, only the fact of a write |
| rdata_o | output | BYTE_W | Read data, valid in the cycle of a read, zero otherwise |

## Verification
A wrong count appears on the very next read of either byte and stays wrong until a clear or preset write. A missed or extra tick therefore shows up in the first read after it. A capture flag that stays set too long, or is never set, first shows in a lower-byte read that either returns a stale byte without a preceding upper-byte read, or returns a live byte right after one. That fault is visible only in the cycle of that read. A synchroniser fault shows at the ports as an external-clock count that differs from the number of pulses applied.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_RD_HI,
        ACC_RD_LO,
        ACC_WR_HI,
        ACC_WR_LO
    } acc_e;

    function automatic acc_e decode_acc(input logic sel, input logic wr, input logic lo);
        if (!sel) return ACC_IDLE;
        if (wr)   return lo ? ACC_WR_LO : ACC_WR_HI;
        return lo ? ACC_RD_LO : ACC_RD_HI;
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q, sync_d;
    logic              last_q, last_d;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], async_i};
        last_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            last_q <= last_d;
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
    parameter bit          EXT_CAPABLE = 1'b1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic ext_clk_i,
    input  logic ext_sel_i,
    output logic tick_o
);
    generate
        if (EXT_CAPABLE) begin : g_ext
            logic ext_rise;
            tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .async_i (ext_clk_i),
                .rise_o  (ext_rise)
            );
            assign tick_o = ext_sel_i ? ext_rise : tick_i;
        end else begin : g_int
            logic unused_ext;
            assign unused_ext = ^{clk, rst_n, ext_clk_i, ext_sel_i};
            assign tick_o = tick_i;
        end
    endgenerate
endmodule

// File: rtl/tmr_byte_port.sv
module tmr_byte_port #(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned CNT_W = 2 * BYTE_W
) (
    input  logic               clk,
    input  tmr_pkg::acc_e      acc_i,
    input  logic               hold_i,
    input  logic [CNT_W-1:0]   cnt_i,
    output logic [BYTE_W-1:0]  rdata_o
);
    import tmr_pkg::*;

    logic [BYTE_W-1:0] snap_q, snap_d;

    always_comb begin
        snap_d = (acc_i == ACC_RD_HI) ? cnt_i[BYTE_W-1:0] : snap_q;
    end

    // The snapshot register is deliberately left out of reset.
    always_ff @(posedge clk) begin
        snap_q <= snap_d;
    end

    always_comb begin
        unique case (acc_i)
            ACC_RD_HI: rdata_o = cnt_i[CNT_W-1:BYTE_W];
            ACC_RD_LO: rdata_o = hold_i ? snap_q : cnt_i[BYTE_W-1:0];
            default:   rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/tmr_count16.sv
module tmr_count16 #(
    parameter bit          EXT_CAPABLE = 1'b1,
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PRESET_VAL  = 32'h0000_FFF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              ext_clk_i,
    input  logic              ext_sel_i,
    input  logic              special_i,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic              addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o
);
    import tmr_pkg::*;

    localparam int unsigned      CNT_W  = 2 * BYTE_W;
    localparam logic [CNT_W-1:0] PRESET = CNT_W'(PRESET_VAL);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             hold;
    } state_t;

    state_t st_q, st_d;
    acc_e   acc;
    logic   tick_now;
    logic [CNT_W-1:0] cnt_now;
    logic   unused_wdata;

    assign unused_wdata = ^wdata_i;
    assign acc          = decode_acc(sel_i, wr_i, addr_i);
    assign cnt_now      = st_q.cnt;

    tmr_tick_sel #(
        .EXT_CAPABLE (EXT_CAPABLE),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .ext_clk_i (ext_clk_i),
        .ext_sel_i (ext_sel_i),
        .tick_o    (tick_now)
    );

    always_comb begin
        st_d      = st_q;
        st_d.hold = (acc == ACC_RD_HI);
        if (special_i && acc == ACC_WR_HI) begin
            st_d.cnt = PRESET;
        end else if (EXT_CAPABLE && !special_i && (acc == ACC_WR_HI || acc == ACC_WR_LO)) begin
            st_d.cnt = '0;
        end else if (tick_now) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tmr_byte_port #(.BYTE_W(BYTE_W)) u_port (
        .clk     (clk),
        .acc_i   (acc),
        .hold_i  (st_q.hold),
        .cnt_i   (st_q.cnt),
        .rdata_o (rdata_o)
    );
endmodule

// File: rtl/tmr_count16_chk.sv
module tmr_count16_chk #(
    parameter bit          EXT_CAPABLE = 1'b1,
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned PRESET_VAL  = 32'h0000_FFF8,
    localparam int unsigned CNT_W      = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_i,
    input logic              wr_i,
    input logic              addr_i,
    input logic              special_i,
    input logic [BYTE_W-1:0] rdata_o,
    input logic [CNT_W-1:0]  cnt,
    input logic              tick
);
    logic rd_hi, rd_lo, wr_any;
    assign rd_hi  = sel_i && !wr_i && !addr_i;
    assign rd_lo  = sel_i && !wr_i &&  addr_i;
    assign wr_any = sel_i && wr_i;

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> cnt == '0);                                                      // R1
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_any && tick) |=> cnt == CNT_W'($past(cnt) + 1'b1));                     // R2
    AST_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi ##1 rd_lo |-> rdata_o == $past(cnt[BYTE_W-1:0]));                      // R3
    AST_LIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !$past(rd_hi)) |-> rdata_o == cnt[BYTE_W-1:0]);                    // R4
    AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !wr_i && !tick) |=> $stable(cnt));                                 // R5
    AST_HIGH_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |-> rdata_o == cnt[CNT_W-1:BYTE_W]);                                   // R5
    AST_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && !addr_i && special_i) |=> cnt == CNT_W'(PRESET_VAL));             // R8
    AST_SPECIAL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && addr_i && special_i && !tick) |=> $stable(cnt));                  // R8
    AST_WR_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && !addr_i && special_i && tick) |=> cnt == CNT_W'(PRESET_VAL));     // R9

    generate
        if (EXT_CAPABLE) begin : g_clr
            AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_any && !special_i) |=> cnt == '0);                               // R7
        end else begin : g_keep
            AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_any && !special_i && !tick) |=> $stable(cnt));                   // R6
        end
    endgenerate
endmodule

bind tmr_count16 tmr_count16_chk #(
    .EXT_CAPABLE (EXT_CAPABLE),
    .BYTE_W      (BYTE_W),
    .PRESET_VAL  (PRESET_VAL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (sel_i),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .special_i (special_i),
    .rdata_o   (rdata_o),
    .cnt       (cnt_now),
    .tick      (tick_now)
);

// File: tb/tmr_count16_test.sv
module tmr_count16_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, ext_clk = 1'b0, ext_sel = 1'b0, special = 1'b0;
    logic sel = 1'b0, wr = 1'b0, addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rd_b, rd_a;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [15:0] m_a = '0, m_b = '0;
    logic [7:0]  snap_a = '0, snap_b = '0;
    bit          m_hold = 0;
    bit          b_ext = 0;
    logic        ext_lvl = 1'b0, ext_sel_lvl = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_count16 #(.EXT_CAPABLE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .ext_clk_i(ext_clk), .ext_sel_i(ext_sel),
        .special_i(special), .sel_i(sel), .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_b)
    );

    tmr_count16 #(.EXT_CAPABLE(1'b0)) uut_a (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .ext_clk_i(ext_clk), .ext_sel_i(ext_sel),
        .special_i(special), .sel_i(sel), .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_a)
    );

    function automatic logic [15:0] next_count(input logic [15:0] cur, input bit ext_cap,
            input bit s, input bit w, input bit a, input bit sp, input bit tk);
        if (s && w && !a && sp)         return 16'hFFF8;  // R8
        if (s && w && !sp && ext_cap)   return 16'h0000;  // R7
        if (tk)                         return cur + 16'h1; // R2
        return cur;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit s, input bit w, input bit a, input bit sp, input bit tk,
                       input string tag);
        string t;
        logic [7:0] ea, eb;
        @(negedge clk);
        sel = s; wr = w; addr = a; special = sp; tick = tk;
        wdata = 8'($urandom);
        ext_clk = ext_lvl; ext_sel = ext_sel_lvl;
        #1;
        if (s && !w) begin
            if (tag != "") t = tag;
            else if (!a)   t = "R5";
            else if (m_hold) t = "R3";
            else           t = "R4";
            ea = a ? (m_hold ? snap_a : m_a[7:0]) : m_a[15:8];
            eb = a ? (m_hold ? snap_b : m_b[7:0]) : m_b[15:8];
            check({t, " fixed"}, rd_a, ea);
            check({t, " flex"},  rd_b, eb);
        end
        @(posedge clk);
        if (s && !w && !a) begin
            snap_a = m_a[7:0];
            snap_b = m_b[7:0];
        end
        m_hold = s && !w && !a;
        m_a = next_count(m_a, 1'b0, s, w, a, sp, tk);
        if (!b_ext) m_b = next_count(m_b, 1'b1, s, w, a, sp, tk);
    endtask

    task automatic read_both(input string tag);
        cyc(1, 0, 0, 0, 0, tag);
        cyc(1, 0, 1, 0, 0, tag);
    endtask

    initial begin
        void'($urandom(32'h1F2E_3D4C));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset value seen on both bytes, and a lone lower-byte read
        read_both("R1");
        cyc(0, 0, 0, 0, 0, "");
        cyc(1, 0, 1, 0, 0, "R1");

        // R2: plain counting
        repeat (5) cyc(0, 0, 0, 0, 1, "");
        read_both("R2");

        // R8: special-mode upper write presets, lower write ignored
        cyc(1, 1, 0, 1, 0, "");
        read_both("R8");
        cyc(1, 1, 1, 1, 0, "");
        read_both("R8");

        // R2: wrap from 0xFFFF to 0x0000
        repeat (8) cyc(0, 0, 0, 0, 1, "");
        read_both("R2");

        // R9: preset wins over a coincident tick
        cyc(1, 1, 0, 1, 1, "");
        read_both("R9");

        // R6 / R7: normal-mode writes with a tick in the same cycle
        repeat (3) cyc(0, 0, 0, 0, 1, "");
        cyc(1, 1, 0, 0, 1, "");
        read_both("R6 R7");
        repeat (2) cyc(0, 0, 0, 0, 1, "");
        cyc(1, 1, 1, 0, 0, "");
        read_both("R6 R7");

        // R3: count moves between the two reads, snapshot must hold
        repeat (20) cyc(0, 0, 0, 0, 1, "");
        cyc(1, 0, 0, 0, 1, "R3");
        cyc(1, 0, 1, 0, 1, "R3");
        // R4: the same lower-byte read one cycle later sees the live count
        cyc(1, 0, 1, 0, 1, "R4");

        // R10: external clock source, tick_i still toggling
        b_ext = 1; ext_sel_lvl = 1'b1;
        cyc(0, 0, 0, 0, 0, "");
        for (int p = 0; p < 5; p++) begin
            ext_lvl = 1'b1;
            repeat (3) cyc(0, 0, 0, 0, 1, "");
            ext_lvl = 1'b0;
            repeat (3) cyc(0, 0, 0, 0, 1, "");
        end
        repeat (4) cyc(0, 0, 0, 0, 1, "");
        m_b = m_b + 16'd5;
        read_both("R10");
        ext_sel_lvl = 1'b0;
        cyc(0, 0, 0, 0, 0, "");
        b_ext = 0;

        // Random traffic on the internal tick
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 4) != 0, ($urandom % 8) == 0, 1'($urandom % 2),
                ($urandom % 4) == 0, 1'($urandom % 2), "");
        end

        read_both("R5");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule